// File: doc/BRIEF.md
# Bundle-Pair Instruction Dispersal Unit

This block sits between an instruction fetch buffer and a bank of typed execution ports in a wide-issue core whose instructions come in three-slot bundles. It keeps a window of two bundles. Every cycle it decodes each bundle's template into a unit class per slot, then walks the six window slots strictly in order. Each pending slot is handed to a free port of its class. The walk stops at the first slot that finds no port, or right after a slot that carries a stop marker.

Fully issued bundles leave the window. A partly issued bundle keeps its leftover slots and moves to the front position. Fetched bundles fill the positions that are free, so leftovers issue together with the next bundle in a later cycle. The block does no register dependency checking: issue groups are bounded only by the stop markers that the compiler places and by running out of ports.

Top module: `bundle_disperse`

## Requirements
- R1: While `rst` is high, `fetch_take` is 0. From the first cycle after reset until bundles arrive, the window is empty, no port is valid and `issue_cnt` is 0.
- R2: A bundle word is `{tmpl[2:0], stop[1:0], alu[2:0], i0only[2:0]}`, MSB first. Bit k of `alu` and of `i0only` refers to slot k. The template gives the classes of slots 0,1,2 as follows: 0=MII, 1=MMI, 2=MFI, 3=MMF, 4=MIB, 5=MBB, 6=BBB, 7=MFB (M memory, I integer, F float, B branch).
- R3: The ports are indexed 0=M0, 1=M1, 2=I0, 3=I1, 4=F0, 5=F1, 6=B0, 7=B1, 8=B2. Within a class, the lowest free port is always taken first.
- R4: Slots are assigned in window order. Slot index = position*3 + slot, where position 0 is the front. At the first pending slot with no usable port, issue stops and every later slot waits.
- R5: `stop` = 0 means no stop. `stop` = n (1..3) ends the issue group after slot n-1 of that bundle once that slot issues. A stop after slot 2 keeps the second bundle from issuing in that cycle.
- R6: An M or I slot with its `alu` bit set may use a free port of the other class of that pair when its own class is exhausted.
- R7: An I slot with its `i0only` bit set may only use I0. If I0 is taken, issue stops at that slot.
- R8: A nop slot still takes a port of its class. When both bundles issue completely, six ports are valid, `retire_cnt` is 2, and two new bundles may be taken that cycle.
- R9: A partly issued bundle keeps its unissued slots. When the front bundle is finished and the second is partial, the second moves to the front, and its leftovers issue first in the next cycle.
- R10: `in_valid` is a contiguous prefix of offered bundles. `fetch_take` = min(free window positions after this cycle's issue, bundles offered), and bundles are taken in order. With nothing offered, the window keeps its leftovers.
- R11: `port_vld` flags the busy ports. `port_slot` gives each busy port's window slot index (0..5). `issue_cnt` counts issued slots (0..6). `retire_cnt` counts bundles leaving the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 2 | Offered fetch bundles (bit 0 first) |
| in_bundle0 | input | 11 | First offered bundle |
| in_bundle1 | input | 11 | Second offered bundle |
| fetch_take | output | 2 | Number of offered bundles accepted this cycle |
| port_vld | output | 9 | Per-port issue valid |
| port_slot | output | 27 | Per-port window slot index, 3 bits per port |
| issue_cnt | output | 3 | Instructions issued this cycle |
| retire_cnt | output | 2 | Bundles completed this cycle |

## Verification
The bench targets stops placed inside a bundle and at its end. A wrong design here would issue slots past the marker, or let the second bundle start after an end-of-bundle stop. It also exercises port exhaustion with slots waiting behind it, I0-only slots that collide, and ALU slots that spill across the memory/integer boundary. A design that skipped a blocked slot and kept issuing later slots, or did not spill, shows up as wrong port flags or slot indices. Fetch stalls and single-bundle offers test rotation and the take count. A design that dropped leftovers, issued them twice, or took bundles into a full window would fall out of step with the model.

// File: rtl/disp_pkg.sv
package disp_pkg;
    localparam int SLOTS   = 3;
    localparam int WIN     = 2;
    localparam int WSLOTS  = SLOTS * WIN;
    localparam int SIDX_W  = $clog2(WSLOTS);
    localparam int CNT_W   = $clog2(WIN + 1);
    localparam int ICNT_W  = $clog2(WSLOTS + 1);
    localparam int N_M     = 2;
    localparam int N_I     = 2;
    localparam int N_F     = 2;
    localparam int N_B     = 3;
    localparam int I_BASE  = N_M;
    localparam int F_BASE  = I_BASE + N_I;
    localparam int B_BASE  = F_BASE + N_F;
    localparam int NPORT   = B_BASE + N_B;

    typedef enum logic [1:0] {UC_MEM = 2'd0, UC_INT = 2'd1, UC_FLT = 2'd2, UC_BR = 2'd3} ucls_e;

    typedef struct packed {
        logic [2:0]       tmpl;
        logic [1:0]       stop;
        logic [SLOTS-1:0] alu;
        logic [SLOTS-1:0] i0only;
    } bundle_t;

    localparam int BW = $bits(bundle_t);

    // per template: slot2,slot1,slot0 classes, two bits each
    localparam logic [7:0][5:0] TMPL_TAB = {
        6'b111000, 6'b111111, 6'b111100, 6'b110100,
        6'b100000, 6'b011000, 6'b010000, 6'b010100
    };

    function automatic ucls_e slot_class(input logic [2:0] t, input int k);
        return ucls_e'(TMPL_TAB[t][k*2 +: 2]);
    endfunction

    function automatic ucls_e port_class(input int p);
        if (p < I_BASE) return UC_MEM;
        if (p < F_BASE) return UC_INT;
        if (p < B_BASE) return UC_FLT;
        return UC_BR;
    endfunction

    function automatic int first_free(input logic [NPORT-1:0] busy, input ucls_e c);
        int r = -1;
        for (int p = NPORT - 1; p >= 0; p--)
            if (port_class(p) == c && !busy[p]) r = p;
        return r;
    endfunction
endpackage

// File: rtl/disp_tmpl_decode.sv
module disp_tmpl_decode
    import disp_pkg::*;
(
    input  logic [2:0]              tmpl,
    output ucls_e [SLOTS-1:0]       cls
);
    always_comb begin
        for (int k = 0; k < SLOTS; k++) cls[k] = slot_class(tmpl, k);
    end
endmodule

// File: rtl/disp_alloc.sv
module disp_alloc
    import disp_pkg::*;
(
    input  ucls_e [WSLOTS-1:0]                 cls,
    input  logic  [WSLOTS-1:0]                 live,
    input  logic  [WSLOTS-1:0]                 pend,
    input  logic  [WSLOTS-1:0]                 stop_after,
    input  logic  [WSLOTS-1:0]                 alu,
    input  logic  [WSLOTS-1:0]                 i0only,
    output logic  [WSLOTS-1:0]                 issued,
    output logic  [NPORT-1:0]                  port_vld,
    output logic  [NPORT-1:0][SIDX_W-1:0]      port_slot
);
    always_comb begin
        logic [NPORT-1:0] busy;
        logic             halt;
        int               pick;
        busy      = '0;
        halt      = 1'b0;
        issued    = '0;
        port_slot = '0;
        for (int s = 0; s < WSLOTS; s++) begin
            pick = -1;
            if (!halt) begin
                if (!live[s]) begin
                    halt = 1'b1;
                end else if (pend[s]) begin
                    if (cls[s] == UC_INT && i0only[s]) begin
                        if (!busy[I_BASE]) pick = I_BASE;
                    end else begin
                        pick = first_free(busy, cls[s]);
                        if (pick < 0 && alu[s] && cls[s] == UC_MEM) pick = first_free(busy, UC_INT);
                        if (pick < 0 && alu[s] && cls[s] == UC_INT) pick = first_free(busy, UC_MEM);
                    end
                    if (pick < 0) begin
                        halt = 1'b1;
                    end else begin
                        busy[pick]      = 1'b1;
                        port_slot[pick] = SIDX_W'(s);
                        issued[s]       = 1'b1;
                        if (stop_after[s]) halt = 1'b1;
                    end
                end
            end
        end
        port_vld = busy;
    end
endmodule

// File: rtl/disp_window.sv
module disp_window
    import disp_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [WSLOTS-1:0]             issued,
    input  logic [WIN-1:0]                in_valid,
    input  bundle_t [WIN-1:0]             in_b,
    output bundle_t [WIN-1:0]             wb,
    output logic [WIN-1:0]                wv,
    output logic [WIN-1:0][SLOTS-1:0]     wd,
    output logic [CNT_W-1:0]              take,
    output logic [CNT_W-1:0]              retire
);
    bundle_t [WIN-1:0]            nb;
    logic [WIN-1:0]               nv;
    logic [WIN-1:0][SLOTS-1:0]    nd;

    always_comb begin
        logic [SLOTS-1:0] dn;
        int kept, ret, avail, tk;
        nb = wb; nv = '0; nd = '0;
        kept = 0; ret = 0; avail = 0;
        for (int i = 0; i < WIN; i++) begin
            dn = wd[i] | issued[i*SLOTS +: SLOTS];
            if (wv[i] && &dn) begin
                ret++;
            end else if (wv[i]) begin
                nb[kept] = wb[i];
                nd[kept] = dn;
                nv[kept] = 1'b1;
                kept++;
            end
        end
        for (int i = 0; i < WIN; i++)
            if (in_valid[i] && avail == i) avail++;
        tk = (WIN - kept < avail) ? WIN - kept : avail;
        if (rst) tk = 0;
        for (int i = 0; i < WIN; i++) begin
            if (i >= kept && i - kept < tk) begin
                nb[i] = in_b[i - kept];
                nd[i] = '0;
                nv[i] = 1'b1;
            end
        end
        take   = CNT_W'(tk);
        retire = CNT_W'(ret);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb <= '0;
            wv <= '0;
            wd <= '0;
        end else begin
            wb <= nb;
            wv <= nv;
            wd <= nd;
        end
    end
endmodule

// File: rtl/bundle_disperse.sv
module bundle_disperse
    import disp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WIN-1:0]              in_valid,
    input  logic [BW-1:0]               in_bundle0,
    input  logic [BW-1:0]               in_bundle1,
    output logic [CNT_W-1:0]            fetch_take,
    output logic [NPORT-1:0]            port_vld,
    output logic [NPORT*SIDX_W-1:0]     port_slot,
    output logic [ICNT_W-1:0]           issue_cnt,
    output logic [CNT_W-1:0]            retire_cnt
);
    bundle_t [WIN-1:0]               wb;
    bundle_t [WIN-1:0]               in_b;
    logic    [WIN-1:0]               wv;
    logic    [WIN-1:0][SLOTS-1:0]    wd;
    ucls_e   [WSLOTS-1:0]            cls;
    logic    [WSLOTS-1:0]            live, pend, stop_after, alu, i0only, issued;
    logic    [NPORT-1:0][SIDX_W-1:0] pslot;

    assign in_b[0] = bundle_t'(in_bundle0);
    assign in_b[1] = bundle_t'(in_bundle1);

    for (genvar b = 0; b < WIN; b++) begin : g_bundle
        disp_tmpl_decode u_dec (
            .tmpl (wb[b].tmpl),
            .cls  (cls[b*SLOTS +: SLOTS])
        );
        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            assign live[b*SLOTS+k]       = wv[b];
            assign pend[b*SLOTS+k]       = wv[b] & ~wd[b][k];
            assign stop_after[b*SLOTS+k] = (wb[b].stop == 2'(k + 1));
            assign alu[b*SLOTS+k]        = wb[b].alu[k];
            assign i0only[b*SLOTS+k]     = wb[b].i0only[k];
        end
    end

    disp_alloc u_alloc (
        .cls        (cls),
        .live       (live),
        .pend       (pend),
        .stop_after (stop_after),
        .alu        (alu),
        .i0only     (i0only),
        .issued     (issued),
        .port_vld   (port_vld),
        .port_slot  (pslot)
    );

    disp_window u_win (
        .clk      (clk),
        .rst      (rst),
        .issued   (issued),
        .in_valid (in_valid),
        .in_b     (in_b),
        .wb       (wb),
        .wv       (wv),
        .wd       (wd),
        .take     (fetch_take),
        .retire   (retire_cnt)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_pslot
        assign port_slot[p*SIDX_W +: SIDX_W] = pslot[p];
    end

    assign issue_cnt = ICNT_W'($countones(issued));
endmodule

// File: rtl/disp_chk.sv
module disp_chk
    import disp_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic [WIN-1:0]            in_valid,
    input logic [CNT_W-1:0]          fetch_take,
    input logic [NPORT-1:0]          port_vld,
    input logic [NPORT*SIDX_W-1:0]   port_slot,
    input logic [ICNT_W-1:0]         issue_cnt,
    input logic [CNT_W-1:0]          retire_cnt
);
    always_ff @(posedge clk) begin
        if (rst) AST_NO_TAKE_IN_RESET: assert (fetch_take == '0); // R1
    end

    AST_CNT_MATCHES_PORTS: assert property (@(posedge clk) disable iff (rst)
        issue_cnt == ICNT_W'($countones(port_vld))); // R11

    AST_FULL_ISSUE_RETIRES_TWO: assert property (@(posedge clk) disable iff (rst)
        issue_cnt == ICNT_W'(WSLOTS) |-> retire_cnt == CNT_W'(WIN)); // R8

    AST_TAKE_WITHIN_OFFER: assert property (@(posedge clk) disable iff (rst)
        fetch_take <= CNT_W'($countones(in_valid))); // R10

    AST_M1_AFTER_M0: assert property (@(posedge clk) disable iff (rst)
        port_vld[1] |-> port_vld[0]); // R3
    AST_I1_AFTER_I0: assert property (@(posedge clk) disable iff (rst)
        port_vld[I_BASE+1] |-> port_vld[I_BASE]); // R3
    AST_F1_AFTER_F0: assert property (@(posedge clk) disable iff (rst)
        port_vld[F_BASE+1] |-> port_vld[F_BASE]); // R3
    AST_B_FILL_ORDER: assert property (@(posedge clk) disable iff (rst)
        port_vld[B_BASE+2] |-> port_vld[B_BASE+1] && port_vld[B_BASE]); // R3

    for (genvar p = 0; p < NPORT; p++) begin : g_rng
        AST_SLOT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
            port_vld[p] |-> port_slot[p*SIDX_W +: SIDX_W] < SIDX_W'(WSLOTS)); // R11
    end
endmodule

bind bundle_disperse disp_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .fetch_take (fetch_take),
    .port_vld   (port_vld),
    .port_slot  (port_slot),
    .issue_cnt  (issue_cnt),
    .retire_cnt (retire_cnt)
);

// File: tb/sim_bundle_disperse.sv
`timescale 1ns/1ps
module sim_bundle_disperse;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  in_valid = '0;
    logic [10:0] in_bundle0 = '0, in_bundle1 = '0;
    logic [1:0]  fetch_take, retire_cnt;
    logic [8:0]  port_vld;
    logic [26:0] port_slot;
    logic [2:0]  issue_cnt;

    always #4 clk = ~clk;

    bundle_disperse u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_bundle0(in_bundle0), .in_bundle1(in_bundle1),
        .fetch_take(fetch_take), .port_vld(port_vld), .port_slot(port_slot),
        .issue_cnt(issue_cnt), .retire_cnt(retire_cnt)
    );

    typedef struct { logic [10:0] b; logic [2:0] d; } went_t;
    went_t       wq[$];
    logic [10:0] sq[$];
    string       tn[8] = '{"MII","MMI","MFI","MMF","MIB","MBB","BBB","MFB"};
    int          checks = 0, errs = 0, cyc = 0;
    logic [8:0]  e_vld;
    int          e_slot[9];
    logic [5:0]  e_iss;
    int          e_cnt;

    function automatic logic [10:0] mk(int t, int st, logic [2:0] a, logic [2:0] z);
        return {3'(t), 2'(st), a, z};
    endfunction

    function automatic void chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s %s got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
        end
    endfunction

    // behavioural reference: greedy in-order port assignment
    function automatic void model_issue();
        int mu = 0, fu = 0, bu = 0;
        bit i0b = 0, i1b = 0, halt = 0;
        e_vld = '0; e_iss = '0; e_cnt = 0;
        for (int p = 0; p < 9; p++) e_slot[p] = 0;
        for (int s = 0; s < 6; s++) begin
            int w = s / 3, k = s % 3, pk = -1;
            if (halt) continue;
            if (w >= wq.size()) begin halt = 1; continue; end
            if (wq[w].d[k]) continue;
            begin
                logic [10:0] bb = wq[w].b;
                byte c = tn[bb[10:8]][k];
                bit a = bb[3+k], z = bb[k];
                if (c == "M") begin
                    if (mu < 2) pk = mu; else if (a) pk = !i0b ? 2 : (!i1b ? 3 : -1);
                end else if (c == "I") begin
                    if (z) pk = !i0b ? 2 : -1;
                    else begin
                        pk = !i0b ? 2 : (!i1b ? 3 : -1);
                        if (pk < 0 && a && mu < 2) pk = mu;
                    end
                end else if (c == "F") begin
                    if (fu < 2) pk = 4 + fu;
                end else begin
                    if (bu < 3) pk = 6 + bu;
                end
                if (pk < 0) halt = 1;
                else begin
                    if (pk < 2) mu++;
                    else if (pk == 2) i0b = 1;
                    else if (pk == 3) i1b = 1;
                    else if (pk < 6) fu++;
                    else bu++;
                    e_vld[pk] = 1; e_slot[pk] = s; e_iss[s] = 1; e_cnt++;
                    if (int'(bb[7:6]) == k + 1) halt = 1;
                end
            end
        end
    endfunction

    task automatic step(string tag, int lim);
        int l, avail, e_take, e_ret;
        went_t nq[$];
        @(negedge clk);
        cyc++;
        l = (lim < 0) ? (cyc % 3) : lim;
        avail = (sq.size() < l) ? sq.size() : l;
        if (rst) avail = 0;
        in_valid   = (avail >= 2) ? 2'b11 : (avail == 1 ? 2'b01 : 2'b00);
        in_bundle0 = (avail >= 1) ? sq[0] : '0;
        in_bundle1 = (avail >= 2) ? sq[1] : '0;
        model_issue();
        e_ret = 0;
        for (int w = 0; w < wq.size(); w++) begin
            wq[w].d |= e_iss[w*3 +: 3];
            if (&wq[w].d) e_ret++; else nq.push_back(wq[w]);
        end
        e_take = (2 - nq.size() < avail) ? 2 - nq.size() : avail;
        if (rst) e_take = 0;
        #1;
        chk(tag, "port_vld", int'(port_vld), int'(e_vld));
        chk(tag, "issue_cnt", int'(issue_cnt), e_cnt);
        chk("R10", "fetch_take", int'(fetch_take), e_take);
        chk(tag, "retire_cnt", int'(retire_cnt), e_ret);
        for (int p = 0; p < 9; p++)
            if (e_vld[p]) chk("R11", $sformatf("slot of port %0d", p), int'(port_slot[p*3 +: 3]), e_slot[p]);
        if (!rst) begin
            wq = nq;
            for (int i = 0; i < e_take; i++) begin
                went_t n;
                n.b = sq.pop_front(); n.d = '0;
                wq.push_back(n);
            end
        end
    endtask

    task automatic run(string tag, int lim);
        int n = 0;
        while ((sq.size() != 0 || wq.size() != 0) && n < 80) begin
            step(tag, lim);
            n++;
        end
        chk(tag, "drained", int'(sq.size() + wq.size()), 0);
    endtask

    initial begin
        #(8 * 150000);
        errs++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        // R1: reset state
        for (int i = 0; i < 3; i++) step("R1", 2);
        rst = 1'b0;
        step("R1", 0);
        // R8: full issue, nops occupy ports (MFI + MIB pairs)
        repeat (3) begin sq.push_back(mk(2, 0, 0, 0)); sq.push_back(mk(4, 0, 0, 0)); end
        run("R8", 2);
        // R5 / R9: stop inside second bundle, leftovers rotate
        sq.push_back(mk(0, 0, 0, 0)); sq.push_back(mk(1, 1, 0, 0)); sq.push_back(mk(4, 0, 0, 0));
        run("R5", 2);
        // R5: stop at end of bundle for every template (R2 decode)
        for (int t = 0; t < 8; t++) sq.push_back(mk(t, 3, 0, 0));
        run("R2", 2);
        // R7: I0-only collision
        sq.push_back(mk(0, 0, 0, 3'b110)); sq.push_back(mk(2, 0, 0, 3'b100));
        run("R7", 2);
        // R6: MMI + MMI with and without ALU spill
        sq.push_back(mk(1, 0, 0, 0)); sq.push_back(mk(1, 0, 3'b001, 0));
        sq.push_back(mk(1, 0, 0, 0)); sq.push_back(mk(1, 0, 0, 0));
        sq.push_back(mk(0, 0, 0, 0)); sq.push_back(mk(0, 0, 3'b110, 0));
        run("R6", 2);
        // R4 / R9: branch exhaustion BBB + MBB
        sq.push_back(mk(6, 0, 0, 0)); sq.push_back(mk(5, 0, 0, 0)); sq.push_back(mk(6, 0, 0, 0));
        run("R4", 2);
        // R10: stalled and single-bundle fetch
        for (int i = 0; i < 10; i++) sq.push_back(mk(i % 8, i % 4, 3'(i), 0));
        run("R10", -1);
        // R3: mixed stream
        for (int i = 0; i < 60; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            sq.push_back(lf[10:0]);
        end
        run("R3", -1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    end
endmodule